// File: doc/BRIEF.md
# Memory-to-Network Transmit DMA Engine

This block moves a block of words out of a dual-port memory onto a network transmit port without processor involvement. It takes four transfer parameters: a memory start address, a word count, a 5-bit network command and a destination network address. A one-cycle start pulse captures them while the engine is idle. The engine first writes the destination address to the port with the address-valid flag raised. It then writes the memory words in address order with the flag low. Every word carries the programmed command.

Memory is read through a pipelined read master. A request is held until the memory drops waitrequest, and the data comes back in order on a readdatavalid strobe. Returned words wait in a small buffer until the port accepts them. The engine reserves a buffer slot for every read it issues, so a full port never causes data loss. When the last word has been sent, a completion bit rises. A start pulse that arrives during a transfer is dropped and sets a sticky flag, which a status-read pulse clears.

Top module: `tx_dma_engine`

## Requirements
- R1: After a synchronous reset, done, tx_ignored, busy, net_we and mem_rd are all 0.
- R2: The first word the port accepts after a start with a non-zero count is cfg_dest on net_data, with net_av = 1 and net_cmd equal to the captured command.
- R3: The next N accepted port words are memory words from addresses base, base+1, … base+N-1, in that order and wrapping modulo the address width. Each has net_av = 0 and the captured command.
- R4: A port word counts as accepted in a cycle where net_we = 1 and net_full = 0. While net_full holds off a write, net_we stays 1 and net_data, net_av and net_cmd stay stable into the next cycle.
- R5: While mem_wait holds off a read request, mem_rd stays 1 and mem_addr stays stable into the next cycle.
- R6: Exactly N reads are accepted per transfer. Reads accepted but not yet sent as port data never exceed BUF_DEPTH (at least 2).
- R7: When the last data word is accepted, busy falls and done reads 1 from the next cycle on.
- R8: A start with a word count of 0 from idle sets done in the next cycle. It sends no port word (not even the address) and issues no memory read.
- R9: A start pulse while busy sets tx_ignored in the next cycle. The running transfer keeps its captured parameters even if the cfg inputs change.
- R10: A stat_read pulse clears tx_ignored in the next cycle. If a start-while-busy occurs in the same cycle, the flag stays set. With no stat_read, the flag stays set after the transfer ends.
- R11: A start with a non-zero count from idle clears done and raises busy in the next cycle.
- R12: While idle, net_we and mem_rd stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_req | input | 1 | One-cycle request to launch a transfer |
| stat_read | input | 1 | Status read pulse, clears tx_ignored |
| cfg_mem_addr | input | AW | Memory start address |
| cfg_words | input | WW | Number of data words |
| cfg_cmd | input | 5 | Network command for every word |
| cfg_dest | input | DW | Destination network address |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last requested word has been sent |
| tx_ignored | output | 1 | Sticky flag: start requested while busy |
| mem_addr | output | AW | Read address |
| mem_rd | output | 1 | Read request |
| mem_wait | input | 1 | Memory stalls the request |
| mem_rdata | input | DW | Returned read data |
| mem_rvalid | input | 1 | Read data valid strobe |
| net_data | output | DW | Port data |
| net_av | output | 1 | Port word is an address |
| net_cmd | output | 5 | Port command |
| net_we | output | 1 | Port write enable |
| net_full | input | 1 | Port cannot accept a word |

## Verification
Transfers are run with the port full almost never, about half the time and most of the time. Memory stalls and return gaps are random throughout. The light-load case confirms ordering and the address-first framing. The heavy-load case keeps the buffer full and separates correct back-pressure from lost or duplicated words. Directed cases cover single-word, zero-count and address-wrap transfers, and starts made while busy with changed cfg inputs. One of these starts coincides with a status read, which separates the priority of setting the flag from clearing it.

// File: rtl/tx_dma_pkg.sv
package tx_dma_pkg;
    localparam int CMD_W = 5;

    typedef logic [CMD_W-1:0] cmd_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    // Circular pointer increment for a buffer of arbitrary depth
    function automatic int unsigned wrap_next(input int unsigned p, input int unsigned depth);
        return (p + 1 == depth) ? 0 : p + 1;
    endfunction
endpackage

// File: rtl/tx_dma_ctrl.sv
module tx_dma_ctrl
    import tx_dma_pkg::*;
#(
    parameter int WW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_req,
    input  logic          stat_read,
    input  logic [WW-1:0] cfg_words,
    input  cmd_t          cfg_cmd,
    input  logic [DW-1:0] cfg_dest,
    input  logic          port_accept,
    output phase_e        phase,
    output cmd_t          cmd_q,
    output logic [DW-1:0] dest_q,
    output logic          launch,
    output logic          done,
    output logic          ignored
);
    logic [WW-1:0] left_q;
    logic          idle;

    assign idle   = (phase == PH_IDLE);
    assign launch = start_req && idle && (cfg_words != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cmd_q  <= '0;
            dest_q <= '0;
            left_q <= '0;
            done   <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start_req) begin
                        done <= (cfg_words == '0);
                        if (cfg_words != '0) begin
                            cmd_q  <= cfg_cmd;
                            dest_q <= cfg_dest;
                            left_q <= cfg_words;
                            phase  <= PH_ADDR;
                        end
                    end
                end
                PH_ADDR: begin
                    if (port_accept) phase <= PH_DATA;
                end
                PH_DATA: begin
                    if (port_accept) begin
                        left_q <= left_q - 1'b1;
                        if (left_q == WW'(1)) begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Sticky flag: a start seen while busy wins over a clearing read
    always_ff @(posedge clk) begin
        if (rst)                    ignored <= 1'b0;
        else if (start_req && !idle) ignored <= 1'b1;
        else if (stat_read)         ignored <= 1'b0;
    end
endmodule

// File: rtl/tx_dma_rdmaster.sv
module tx_dma_rdmaster #(
    parameter int AW        = 16,
    parameter int WW        = 8,
    parameter int BUF_DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          launch,
    input  logic [AW-1:0] cfg_mem_addr,
    input  logic [WW-1:0] cfg_words,
    input  logic          mem_wait,
    input  logic          slot_free,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd
);
    localparam int CW = $clog2(BUF_DEPTH + 1);

    logic [WW-1:0] to_issue_q;
    logic [CW-1:0] reserved_q;
    logic          accepted;

    // Every issued read holds a buffer slot until its word leaves the port
    assign mem_rd   = (to_issue_q != '0) && (reserved_q < CW'(BUF_DEPTH));
    assign accepted = mem_rd && !mem_wait;

    always_ff @(posedge clk) begin
        if (rst) begin
            to_issue_q <= '0;
            mem_addr   <= '0;
        end else if (launch) begin
            to_issue_q <= cfg_words;
            mem_addr   <= cfg_mem_addr;
        end else if (accepted) begin
            to_issue_q <= to_issue_q - 1'b1;
            mem_addr   <= mem_addr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) reserved_q <= '0;
        else begin
            unique case ({accepted, slot_free})
                2'b10:   reserved_q <= reserved_q + 1'b1;
                2'b01:   reserved_q <= reserved_q - 1'b1;
                default: reserved_q <= reserved_q;
            endcase
        end
    end
endmodule

// File: rtl/tx_dma_buf.sv
module tx_dma_buf
    import tx_dma_pkg::*;
#(
    parameter int DW        = 32,
    parameter int BUF_DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          valid
);
    localparam int PW = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;
    localparam int CW = $clog2(BUF_DEPTH + 1);

    logic [DW-1:0] store [BUF_DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;

    assign valid = (cnt_q != '0);
    assign head  = store[rd_q];

    always_ff @(posedge clk) begin
        if (push) store[wr_q] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= PW'(wrap_next(32'(wr_q), BUF_DEPTH));
            if (pop)  rd_q <= PW'(wrap_next(32'(rd_q), BUF_DEPTH));
            unique case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/tx_dma_engine.sv
module tx_dma_engine
    import tx_dma_pkg::*;
#(
    parameter int AW        = 16,
    parameter int WW        = 8,
    parameter int DW        = 32,
    parameter int BUF_DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_req,
    input  logic          stat_read,
    input  logic [AW-1:0] cfg_mem_addr,
    input  logic [WW-1:0] cfg_words,
    input  logic [4:0]    cfg_cmd,
    input  logic [DW-1:0] cfg_dest,
    output logic          busy,
    output logic          done,
    output logic          tx_ignored,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    input  logic          mem_wait,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_rvalid,
    output logic [DW-1:0] net_data,
    output logic          net_av,
    output logic [4:0]    net_cmd,
    output logic          net_we,
    input  logic          net_full
);
    phase_e        phase;
    cmd_t          cmd_q;
    logic [DW-1:0] dest_q;
    logic          launch;
    logic          port_accept;
    logic          data_pop;
    logic [DW-1:0] buf_head;
    logic          buf_valid;

    tx_dma_ctrl #(.WW(WW), .DW(DW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_req  (start_req),
        .stat_read  (stat_read),
        .cfg_words  (cfg_words),
        .cfg_cmd    (cfg_cmd),
        .cfg_dest   (cfg_dest),
        .port_accept(port_accept),
        .phase      (phase),
        .cmd_q      (cmd_q),
        .dest_q     (dest_q),
        .launch     (launch),
        .done       (done),
        .ignored    (tx_ignored)
    );

    tx_dma_rdmaster #(.AW(AW), .WW(WW), .BUF_DEPTH(BUF_DEPTH)) u_rd (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .cfg_mem_addr(cfg_mem_addr),
        .cfg_words   (cfg_words),
        .mem_wait    (mem_wait),
        .slot_free   (data_pop),
        .mem_addr    (mem_addr),
        .mem_rd      (mem_rd)
    );

    tx_dma_buf #(.DW(DW), .BUF_DEPTH(BUF_DEPTH)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .push     (mem_rvalid),
        .push_data(mem_rdata),
        .pop      (data_pop),
        .head     (buf_head),
        .valid    (buf_valid)
    );

    always_comb begin
        busy     = (phase != PH_IDLE);
        net_cmd  = cmd_q;
        net_av   = (phase == PH_ADDR);
        net_data = (phase == PH_ADDR) ? dest_q : buf_head;
        net_we   = (phase == PH_ADDR) || ((phase == PH_DATA) && buf_valid);
    end

    assign port_accept = net_we && !net_full;
    assign data_pop    = port_accept && (phase == PH_DATA);
endmodule

// File: rtl/tx_dma_checker.sv
module tx_dma_checker #(
    parameter int AW        = 16,
    parameter int WW        = 8,
    parameter int DW        = 32,
    parameter int BUF_DEPTH = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          start_req,
    input logic          stat_read,
    input logic [WW-1:0] cfg_words,
    input logic          busy,
    input logic          done,
    input logic          tx_ignored,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd,
    input logic          mem_wait,
    input logic [DW-1:0] net_data,
    input logic          net_av,
    input logic [4:0]    net_cmd,
    input logic          net_we,
    input logic          net_full
);
    logic [7:0] occ_q;

    // Reads accepted minus data words sent, seen only at the ports
    always_ff @(posedge clk) begin
        if (rst) occ_q <= '0;
        else occ_q <= occ_q + 8'(mem_rd && !mem_wait) - 8'(net_we && !net_full && !net_av);
    end

    a_r2_addr_first: assert property (@(posedge clk) disable iff (rst)
        start_req && !busy && cfg_words != '0 |=> net_we && net_av);
    a_r4_port_hold: assert property (@(posedge clk) disable iff (rst)
        net_we && net_full |=> net_we && $stable(net_data) && $stable(net_av) && $stable(net_cmd));
    a_r5_read_hold: assert property (@(posedge clk) disable iff (rst)
        mem_rd && mem_wait |=> mem_rd && $stable(mem_addr));
    a_r6_buffer_bound: assert property (@(posedge clk) disable iff (rst)
        occ_q <= 8'(BUF_DEPTH));
    a_r7_done_at_end: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
    a_r8_zero_count: assert property (@(posedge clk) disable iff (rst)
        start_req && !busy && cfg_words == '0 |=> done && !busy);
    a_r9_ignored_set: assert property (@(posedge clk) disable iff (rst)
        start_req && busy |=> tx_ignored);
    a_r10_read_clears: assert property (@(posedge clk) disable iff (rst)
        stat_read && !(start_req && busy) |=> !tx_ignored);
    a_r11_done_clear: assert property (@(posedge clk) disable iff (rst)
        start_req && !busy && cfg_words != '0 |=> !done && busy);
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !net_we && !mem_rd);
endmodule

bind tx_dma_engine tx_dma_checker #(.AW(AW), .WW(WW), .DW(DW), .BUF_DEPTH(BUF_DEPTH)) u_chk (
    .clk(clk), .rst(rst), .start_req(start_req), .stat_read(stat_read),
    .cfg_words(cfg_words), .busy(busy), .done(done), .tx_ignored(tx_ignored),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wait(mem_wait),
    .net_data(net_data), .net_av(net_av), .net_cmd(net_cmd),
    .net_we(net_we), .net_full(net_full)
);

// File: tb/sim_tx_dma_engine.sv
module sim_tx_dma_engine;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16, WW = 8, DW = 32, BUF_DEPTH = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic start_req = 0, stat_read = 0;
    logic [AW-1:0] cfg_mem_addr = '0;
    logic [WW-1:0] cfg_words = '0;
    logic [4:0] cfg_cmd = '0;
    logic [DW-1:0] cfg_dest = '0;
    logic busy, done, tx_ignored, mem_rd, net_av, net_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] net_data;
    logic [4:0] net_cmd;
    logic mem_wait = 0, mem_rvalid = 0, net_full = 0;
    logic [DW-1:0] mem_rdata = '0;

    int checks = 0, errors = 0, cycles = 0;
    int full_pct = 0;
    int nreads = 0;
    logic [AW-1:0] rdq[$];
    logic [DW-1:0] cap_data[$];
    logic cap_av[$];
    logic [4:0] cap_cmd[$];

    tx_dma_engine #(.AW(AW), .WW(WW), .DW(DW), .BUF_DEPTH(BUF_DEPTH)) u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
        return {a, ~a} ^ 32'h3C5A_0F96;
    endfunction

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Memory and port models: drive at the falling edge, sample just after
    always @(negedge clk) begin
        cycles++;
        if (rst) begin
            mem_rvalid = 0; mem_wait = 0; net_full = 0;
        end else begin
            mem_rvalid = 0;
            if (rdq.size() > 0 && $urandom % 100 < 70) begin
                mem_rvalid = 1;
                mem_rdata = mem_val(rdq.pop_front());
            end
            mem_wait = ($urandom % 100) < 30;
            net_full = ($urandom % 100) < full_pct;
            #1;
            if (mem_rd && !mem_wait) begin
                rdq.push_back(mem_addr);
                nreads++;
            end
            if (net_we && !net_full) begin
                cap_data.push_back(net_data);
                cap_av.push_back(net_av);
                cap_cmd.push_back(net_cmd);
            end
        end
    end

    // mode: 0 none, 1 start while busy, 2 start while busy with stat_read
    task automatic run_xfer(input logic [AW-1:0] base, input logic [WW-1:0] n,
                            input logic [4:0] cmd, input logic [DW-1:0] dest,
                            input int mode, input int fpct);
        int cyc = 0;
        full_pct = fpct;
        cap_data.delete(); cap_av.delete(); cap_cmd.delete(); nreads = 0;
        @(negedge clk);
        cfg_mem_addr = base; cfg_words = n; cfg_cmd = cmd; cfg_dest = dest; start_req = 1;
        @(negedge clk);
        start_req = 0;
        if (n == 0) begin
            check(done == 1 && busy == 0, "R8 zero count done", {30'd0, busy, done}, 32'd1);
            repeat (4) @(negedge clk);
            check(cap_data.size() == 0 && nreads == 0, "R8 nothing sent", cap_data.size() + nreads, 0);
            return;
        end
        check(done == 0 && busy == 1, "R11 start clears done", {30'd0, busy, done}, 32'd2);
        while (busy && cyc < 5000) begin
            if (mode != 0 && cyc == 2) begin
                cfg_mem_addr = base + 16'h0100; cfg_words = n + 3; cfg_cmd = ~cmd; cfg_dest = ~dest;
                start_req = 1; stat_read = (mode == 2);
                @(negedge clk);
                start_req = 0; stat_read = 0;
                check(tx_ignored == 1, "R9/R10 start while busy sets flag", tx_ignored, 1);
            end else @(negedge clk);
            cyc++;
        end
        check(busy == 0, "R7 transfer completes", busy, 0);
        check(done == 1, "R7 done after last word", done, 1);
        check(nreads == int'(n), "R6 read count", nreads, n);
        check(cap_data.size() == int'(n) + 1, "R2/R3 word count", cap_data.size(), n + 1);
        if (cap_data.size() == int'(n) + 1) begin
            check(cap_av[0] == 1 && cap_data[0] == dest && cap_cmd[0] == cmd,
                  "R2 address word", cap_data[0], dest);
            for (int i = 1; i <= int'(n); i++) begin
                logic [AW-1:0] a = base + AW'(i - 1);
                check(cap_av[i] == 0 && cap_data[i] == mem_val(a) && cap_cmd[i] == cmd,
                      "R3 data word", cap_data[i], mem_val(a));
            end
        end
    endtask

    initial begin
        while (cycles < 150000) @(negedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 0;
        check(done == 0 && tx_ignored == 0 && busy == 0, "R1 reset status",
              {29'd0, busy, tx_ignored, done}, 0);
        check(net_we == 0 && mem_rd == 0, "R1 reset outputs", {30'd0, net_we, mem_rd}, 0);
        repeat (5) @(negedge clk);
        check(cap_data.size() == 0 && nreads == 0, "R12 idle quiet", cap_data.size() + nreads, 0);

        run_xfer(16'h0040, 8'd1, 5'h03, 32'hA000_0001, 0, 0);
        run_xfer(16'h0000, 8'd0, 5'h01, 32'h1, 0, 0);            // R8
        run_xfer(16'hFFFE, 8'd4, 5'h1F, 32'hB000_0002, 0, 20);   // wrap
        run_xfer(16'h1200, 8'd12, 5'h0A, 32'hC000_0003, 0, 85);  // heavy back-pressure
        run_xfer(16'h2200, 8'd9, 5'h11, 32'hD000_0004, 1, 40);   // R9
        check(tx_ignored == 1, "R10 flag sticky after transfer", tx_ignored, 1);
        @(negedge clk); stat_read = 1;
        @(negedge clk); stat_read = 0;
        check(tx_ignored == 0, "R10 stat_read clears", tx_ignored, 0);
        run_xfer(16'h3300, 8'd6, 5'h05, 32'hE000_0005, 2, 50);   // R10 set wins
        check(tx_ignored == 1, "R10 set wins over read", tx_ignored, 1);
        @(negedge clk); stat_read = 1;
        @(negedge clk); stat_read = 0;

        for (int k = 0; k < 20; k++) begin
            run_xfer(AW'($urandom), WW'(1 + $urandom % 20), 5'($urandom),
                     $urandom, 0, int'($urandom % 90));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule